// File: doc/BRIEF.md
# Branch Direction Predictor with Static Fallback

This block guesses, at fetch time, whether a conditional branch will be taken. The fetch stage presents the fetch address together with a predecode flag saying the word is a conditional branch, a sign bit saying whether its displacement points backward, and a per-instruction hint bit. The block answers in the same cycle with a single predict-taken bit. Words that are not branches always get a not-taken answer.

The answer comes from a history table indexed by a slice of the fetch address. A parameter selects the entry format: either one bit that remembers the last outcome, or a two-bit saturating counter with two taken states and two not-taken states. Every entry carries a valid bit that reset clears. While an entry is still invalid, the block uses a static rule instead: backward branches are guessed taken and forward branches not taken, and a set hint bit inverts that guess.

When a branch resolves later in the pipeline, the resolve port delivers its address and its real outcome. On that clock edge the entry is written and marked valid; a lookup of the same entry in that cycle still sees the old contents. A fresh two-bit entry starts in the weak state that agrees with the outcome that created it.

Top module: `bdp_predictor`

## Requirements
- R1: When `lk_is_br` is 0, `lk_taken` is 0 regardless of every other input and of the table contents.
- R2: For a branch whose entry is invalid and whose hint is 0, `lk_taken` equals `lk_backward` (1 = backward displacement gives taken, 0 = forward gives not taken).
- R3: For a branch whose entry is invalid, a hint of 1 inverts the R2 guess (backward gives not taken, forward gives taken).
- R4: The entry is selected by address bits [7:2] (with the default parameters); addresses that agree in those bits share one entry, and bits [1:0] and bits above 7 have no effect on the selection.
- R5: Once an entry is valid, `lk_backward` and `lk_hint` have no effect on `lk_taken`.
- R6: With one-bit history, a valid entry predicts the outcome of the most recent resolve written to it.
- R7: With two-bit history, the first resolve into an invalid entry leaves it in the weak state matching the outcome, so one resolve of the opposite outcome reverses the prediction.
- R8: With two-bit history, a counter saturates at the strong states, and a single mispredict from a strong state keeps the prediction unchanged.
- R9: A resolve writes the entry and sets its valid bit on the clock edge; a lookup of that entry in the same cycle returns the value from before the write, and the new value from the next cycle on.
- R10: Reset clears every valid bit, so after reset all branches are predicted by the static rule.
- R11: With two-bit history, a branch following the repeating outcome pattern taken, taken, taken, not-taken is mispredicted exactly once per four-outcome iteration once warmed up (one-bit history mispredicts twice).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_pc | input | PC_W | Fetch address being looked up |
| lk_is_br | input | 1 | Predecode: the fetched word is a conditional branch |
| lk_backward | input | 1 | 1 when the branch displacement is negative |
| lk_hint | input | 1 | 1 inverts the static guess |
| lk_taken | output | 1 | Predicted taken, combinational from the lookup inputs |
| rs_valid | input | 1 | A branch resolves this cycle |
| rs_pc | input | PC_W | Address of the resolving branch |
| rs_taken | input | 1 | Real outcome of the resolving branch |

## Verification
The bench writes and reads one entry in the same cycle to catch a design that forwards the new value early, and it starts fresh entries with a single resolve followed by one opposite outcome, which exposes a design that allocates strong states (the prediction would not turn). It loads a strong counter and applies one mispredict to catch a counter that flips directly, and it aliases addresses that differ only outside the index field to catch a wrong index slice. A looping outcome pattern is counted for mispredicts in both history widths, and a second reset shows whether valid bits really clear, since a stale table would keep its trained answer instead of the static one.

// File: rtl/bdp_pkg.sv
package bdp_pkg;

   // Two-bit counter encoding: the upper bit is the prediction.
   localparam logic [1:0] CTR_STRONG_NT = 2'b00;
   localparam logic [1:0] CTR_WEAK_NT   = 2'b01;
   localparam logic [1:0] CTR_WEAK_T    = 2'b10;
   localparam logic [1:0] CTR_STRONG_T  = 2'b11;

   // Saturating step toward the observed outcome.
   function automatic logic [1:0] ctr_step(input logic [1:0] cur, input logic taken);
      logic [1:0] res;
      res = cur;
      if (taken && cur != CTR_STRONG_T)
         res = cur + 2'd1;
      else if (!taken && cur != CTR_STRONG_NT)
         res = cur - 2'd1;
      return res;
   endfunction

   // Starting state for an entry that has never been written.
   function automatic logic [1:0] ctr_alloc(input logic taken);
      return taken ? CTR_WEAK_T : CTR_WEAK_NT;
   endfunction

endpackage

// File: rtl/bdp_index.sv
module bdp_index #(
   parameter int PC_W    = 32,
   parameter int IDX_LSB = 2,
   parameter int IDX_W   = 6
) (
   input  logic [PC_W-1:0]  pc,
   output logic [IDX_W-1:0] idx
);
   localparam int IDX_MSB = IDX_LSB + IDX_W - 1;

   if (IDX_MSB >= PC_W) begin : g_bad_slice
      $error("bdp_index: index field exceeds address width");
   end

   assign idx = pc[IDX_MSB:IDX_LSB];

endmodule

// File: rtl/bdp_static_rule.sv
module bdp_static_rule (
   input  logic backward,
   input  logic hint,
   output logic guess
);
   logic base_guess;

   // Backward displacement (loop closing branch) is guessed taken.
   always_comb begin
      base_guess = backward;
      guess      = base_guess ^ hint;
   end

endmodule

// File: rtl/bdp_hist_table.sv
module bdp_hist_table
   import bdp_pkg::*;
#(
   parameter int IDX_W     = 6,
   parameter int HIST_BITS = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_idx,
   output logic             rd_hit,
   output logic             rd_pred,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic             wr_taken
);
   localparam int ENTRIES = 1 << IDX_W;
   localparam int TOP     = HIST_BITS - 1;

   if (!(HIST_BITS == 1 || HIST_BITS == 2)) begin : g_bad_hist
      $error("bdp_hist_table: HIST_BITS must be 1 or 2");
   end
   if (IDX_W < 1 || IDX_W > 10) begin : g_bad_depth
      $error("bdp_hist_table: IDX_W out of range");
   end

   logic [ENTRIES-1:0]                vld;
   logic [ENTRIES-1:0][HIST_BITS-1:0] st;
   logic [HIST_BITS-1:0]              wr_next;
   logic                              wr_was_vld;
   logic [HIST_BITS-1:0]              wr_cur;

   assign wr_was_vld = vld[wr_idx];
   assign wr_cur     = st[wr_idx];

   // Read side: old contents, no bypass from the write port.
   assign rd_hit  = vld[rd_idx];
   assign rd_pred = st[rd_idx][TOP];

   if (HIST_BITS == 1) begin : g_last_outcome
      // A changed outcome flips the bit; equal outcome leaves it alone.
      always_comb begin
         wr_next = wr_cur;
         if (!wr_was_vld || wr_cur[0] != wr_taken)
            wr_next = wr_taken;
      end

      assert_last_outcome_R6: assert property (@(posedge clk) disable iff (!rst_n)
         wr_en |=> st[$past(wr_idx)][0] == $past(wr_taken));
   end else begin : g_sat_counter
      always_comb begin
         if (!wr_was_vld)
            wr_next = ctr_alloc(wr_taken);
         else
            wr_next = ctr_step(wr_cur, wr_taken);
      end

      assert_alloc_weak_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && !wr_was_vld) |=>
            (st[$past(wr_idx)] == CTR_WEAK_T || st[$past(wr_idx)] == CTR_WEAK_NT));

      assert_strong_keeps_dir_R8: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && wr_was_vld && wr_cur == CTR_STRONG_T && !wr_taken) |=>
            st[$past(wr_idx)] == CTR_WEAK_T);

      assert_saturate_R8: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && wr_was_vld && wr_cur == CTR_STRONG_NT && !wr_taken) |=>
            st[$past(wr_idx)] == CTR_STRONG_NT);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld <= '0;
         st  <= '0;
      end else if (wr_en) begin
         vld[wr_idx] <= 1'b1;
         st[wr_idx]  <= wr_next;
      end
   end

   assert_write_sets_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> vld[$past(wr_idx)]);

   assert_reset_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> vld == '0);

endmodule

// File: rtl/bdp_predictor.sv
module bdp_predictor #(
   parameter int PC_W      = 32,
   parameter int IDX_LSB   = 2,
   parameter int IDX_W     = 6,
   parameter int HIST_BITS = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [PC_W-1:0] lk_pc,
   input  logic            lk_is_br,
   input  logic            lk_backward,
   input  logic            lk_hint,
   output logic            lk_taken,
   input  logic            rs_valid,
   input  logic [PC_W-1:0] rs_pc,
   input  logic            rs_taken
);
   logic [IDX_W-1:0] lk_idx;
   logic [IDX_W-1:0] rs_idx;
   logic             tbl_hit;
   logic             tbl_pred;
   logic             fallback;

   bdp_index #(.PC_W(PC_W), .IDX_LSB(IDX_LSB), .IDX_W(IDX_W)) u_lk_index (
      .pc  (lk_pc),
      .idx (lk_idx)
   );

   bdp_index #(.PC_W(PC_W), .IDX_LSB(IDX_LSB), .IDX_W(IDX_W)) u_rs_index (
      .pc  (rs_pc),
      .idx (rs_idx)
   );

   bdp_static_rule u_static (
      .backward (lk_backward),
      .hint     (lk_hint),
      .guess    (fallback)
   );

   bdp_hist_table #(.IDX_W(IDX_W), .HIST_BITS(HIST_BITS)) u_table (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_idx   (lk_idx),
      .rd_hit   (tbl_hit),
      .rd_pred  (tbl_pred),
      .wr_en    (rs_valid),
      .wr_idx   (rs_idx),
      .wr_taken (rs_taken)
   );

   always_comb begin
      lk_taken = 1'b0;
      if (lk_is_br)
         lk_taken = tbl_hit ? tbl_pred : fallback;
   end

   assert_nonbranch_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_is_br |-> !lk_taken);

   assert_static_backward_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_is_br && !tbl_hit && !lk_hint) |-> lk_taken == lk_backward);

   assert_hint_inverts_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_is_br && !tbl_hit && lk_hint) |-> lk_taken == !lk_backward);

endmodule

// File: tb/sim_bdp_predictor.sv
module sim_bdp_predictor;
   localparam int PC_W = 32;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [PC_W-1:0] lk_pc = '0;
   logic            lk_is_br = 1'b0;
   logic            lk_backward = 1'b0;
   logic            lk_hint = 1'b0;
   logic            rs_valid = 1'b0;
   logic [PC_W-1:0] rs_pc = '0;
   logic            rs_taken = 1'b0;
   logic            p2;
   logic            p1;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   bdp_predictor #(.PC_W(PC_W), .HIST_BITS(2)) u0 (
      .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_is_br(lk_is_br),
      .lk_backward(lk_backward), .lk_hint(lk_hint), .lk_taken(p2),
      .rs_valid(rs_valid), .rs_pc(rs_pc), .rs_taken(rs_taken));

   bdp_predictor #(.PC_W(PC_W), .HIST_BITS(1)) u1 (
      .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_is_br(lk_is_br),
      .lk_backward(lk_backward), .lk_hint(lk_hint), .lk_taken(p1),
      .rs_valid(rs_valid), .rs_pc(rs_pc), .rs_taken(rs_taken));

   // Static-rule vectors on an empty table: {pc[7:0], is_br, backward, hint, expected}
   localparam logic [11:0] VEC [8] = '{
      {8'h08, 1'b0, 1'b1, 1'b0, 1'b0},
      {8'h08, 1'b0, 1'b0, 1'b1, 1'b0},
      {8'h08, 1'b1, 1'b1, 1'b0, 1'b1},
      {8'h08, 1'b1, 1'b0, 1'b0, 1'b0},
      {8'h0C, 1'b1, 1'b1, 1'b1, 1'b0},
      {8'h0C, 1'b1, 1'b0, 1'b1, 1'b1},
      {8'h3B, 1'b1, 1'b1, 1'b0, 1'b1},
      {8'hFC, 1'b1, 1'b0, 1'b0, 1'b0}
   };

   task automatic check(input string tag, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: got %0b expected %0b", tag, act, exp);
      end
   endtask

   // Apply inputs at the falling edge and settle before sampling.
   task automatic step(input logic [PC_W-1:0] pc, input logic br, input logic back,
                       input logic hint, input logic rv, input logic [PC_W-1:0] rpc,
                       input logic rt);
      @(negedge clk);
      lk_pc = pc; lk_is_br = br; lk_backward = back; lk_hint = hint;
      rs_valid = rv; rs_pc = rpc; rs_taken = rt;
      #5;
   endtask

   task automatic look(input logic [PC_W-1:0] pc, input logic back, input logic hint);
      step(pc, 1'b1, back, hint, 1'b0, '0, 1'b0);
   endtask

   task automatic resolve(input logic [PC_W-1:0] pc, input logic t);
      step(pc, 1'b0, 1'b0, 1'b0, 1'b1, pc, t);
   endtask

   initial begin
      #3_000_000;
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  %0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      // R10: during reset the table is empty, static rule answers
      look(32'h10, 1'b1, 1'b0);
      check("R10 reset backward 2b", p2, 1'b1);
      check("R10 reset backward 1b", p1, 1'b1);
      repeat (2) @(negedge clk);
      rst_n = 1'b1;

      // R1 R2 R3 R4: vector walk on the empty table
      for (int i = 0; i < 8; i++) begin
         step({24'h0, VEC[i][11:4]}, VEC[i][3], VEC[i][2], VEC[i][1], 1'b0, '0, 1'b0);
         check("R1/R2/R3 static vector 2b", p2, VEC[i][0]);
         check("R1/R2/R3 static vector 1b", p1, VEC[i][0]);
      end

      // R9: same-cycle lookup of the entry being written sees the old value
      step(32'h10, 1'b1, 1'b0, 1'b0, 1'b1, 32'h10, 1'b1);
      check("R9 same cycle old 2b", p2, 1'b0);
      check("R9 same cycle old 1b", p1, 1'b0);
      look(32'h10, 1'b0, 1'b0);
      check("R9 next cycle new 2b", p2, 1'b1);
      check("R6 last outcome taken 1b", p1, 1'b1);

      // R4: aliasing through bits [7:2] only
      look(32'h0000_0113, 1'b0, 1'b0);
      check("R4 alias high and low bits", p2, 1'b1);
      look(32'h14, 1'b0, 1'b0);
      check("R4 neighbour entry untouched", p2, 1'b0);

      // R5: valid entry ignores direction and hint
      look(32'h10, 1'b0, 1'b1);
      check("R5 hint ignored", p2, 1'b1);
      look(32'h10, 1'b1, 1'b1);
      check("R5 backward+hint ignored", p2, 1'b1);

      // R1: non-branch stays quiet on a trained entry
      step(32'h10, 1'b0, 1'b1, 1'b0, 1'b0, '0, 1'b0);
      check("R1 non-branch trained 2b", p2, 1'b0);

      // R7: weak taken allocation turns on one not-taken
      resolve(32'h10, 1'b0);
      look(32'h10, 1'b1, 1'b0);
      check("R7 weak taken turns 2b", p2, 1'b0);
      check("R6 last outcome not-taken 1b", p1, 1'b0);

      // R7: weak not-taken allocation on a backward branch
      resolve(32'h24, 1'b0);
      look(32'h24, 1'b1, 1'b0);
      check("R7 alloc not-taken 2b", p2, 1'b0);
      resolve(32'h24, 1'b1);
      look(32'h24, 1'b0, 1'b0);
      check("R7 weak not-taken turns 2b", p2, 1'b1);

      // R8: strong taken survives one mispredict, second one turns it
      resolve(32'h20, 1'b1);
      resolve(32'h20, 1'b1);
      resolve(32'h20, 1'b1);
      resolve(32'h20, 1'b0);
      look(32'h20, 1'b0, 1'b0);
      check("R8 strong keeps direction 2b", p2, 1'b1);
      check("R6 flips on change 1b", p1, 1'b0);
      resolve(32'h20, 1'b0);
      look(32'h20, 1'b0, 1'b0);
      check("R8 second miss turns 2b", p2, 1'b0);
      // saturate at strong not-taken, then one taken must not turn it
      resolve(32'h20, 1'b0);
      resolve(32'h20, 1'b0);
      resolve(32'h20, 1'b1);
      look(32'h20, 1'b1, 1'b0);
      check("R8 saturated not-taken 2b", p2, 1'b0);

      // R11: loop pattern T,T,T,N on a backward branch
      begin
         int miss2 [6];
         int miss1 [6];
         for (int it = 0; it < 6; it++) begin
            miss2[it] = 0;
            miss1[it] = 0;
            for (int k = 0; k < 4; k++) begin
               logic outc;
               outc = (k != 3);
               step(32'h40, 1'b1, 1'b1, 1'b0, 1'b1, 32'h40, outc);
               if (p2 != outc) miss2[it]++;
               if (p1 != outc) miss1[it]++;
            end
         end
         for (int it = 1; it < 6; it++) begin
            checks++;
            if (miss2[it] != 1) begin
               fails++;
               $display("FAIL R11 loop 2b iter %0d: got %0d expected 1", it, miss2[it]);
            end
            checks++;
            if (miss1[it] != 2) begin
               fails++;
               $display("FAIL R11 loop 1b iter %0d: got %0d expected 2", it, miss1[it]);
            end
         end
      end

      // R10: second reset empties the table again
      @(negedge clk);
      rs_valid = 1'b0;
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      look(32'h40, 1'b0, 1'b0);
      check("R10 cleared loop entry 2b", p2, 1'b0);
      check("R10 cleared loop entry 1b", p1, 1'b0);
      look(32'h24, 1'b0, 1'b1);
      check("R10 cleared entry uses hint", p2, 1'b1);

      done = 1'b1;
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule